// File: doc/BRIEF.md
# Banked Interrupt Group Register Bank

This block stores the group assignment of every interrupt handled by an interrupt distributor. Each interrupt carries one group bit: 0 places it in group 0 (secure, higher priority, signalled as IRQ or FIQ), and 1 places it in group 1 (non-secure, lower priority, always signalled as IRQ). Software reaches the bits through a byte-wide register port. Each byte of the group window covers eight consecutive interrupt IDs. The block also exports a per-CPU, per-interrupt group vector for the downstream prioritisation and signalling logic.

The 32 lowest interrupt IDs are private to each CPU. Each CPU holds its own copy of their group bits, and the requesting CPU's index selects the copy. IDs from 32 upward are shared, and one write updates them for every CPU at once. Configuration inputs give the controller revision, whether security extensions are present, and how many interrupts are implemented. Together these decide whether an access is honoured, read as zero with the write dropped, or flagged as a bad register access.

Every request is answered exactly one cycle later on the response outputs.

Top module: `irq_group_bank`

## Requirements
- R1: After reset every group bit of every CPU is 0, `grp_vec` is all zero and `rsp_valid` is low.
- R2: Byte offset 0x80+k addresses interrupts 8k..8k+7, with data bit i belonging to interrupt 8k+i. A read returns the stored bits, and `grp_vec[c*N_IRQ + id]` carries CPU c's bit for interrupt id.
- R3: A write to a byte of shared interrupts (offset 0x84 and above) changes the bits for all CPUs together. A read from any CPU returns the same value.
- R4: Bytes 0x80 to 0x83 (interrupts 0 to 31) are banked per CPU. A write changes only the requesting CPU's copy, and a read returns only that CPU's copy.
- R5: Grouping exists only when `cfg_rev` is 2, or when `cfg_rev` is 1 and `cfg_sec_ext` is 1. Otherwise every group access reads 0, ignores its write and raises no bad flag.
- R6: When `cfg_sec_ext` is 1, an access with `req_secure` = 0 reads 0, ignores its write and raises no bad flag.
- R7: Take an honoured access whose first interrupt ID 8k is at or above the smaller of `cfg_num_irq` and `N_IRQ`. It pulses `rsp_bad`, returns 0 and changes no bit.
- R8: `rsp_valid`, `rsp_rdata` and `rsp_bad` are presented in the cycle after the request and last one cycle. A write is visible to a read issued in the next request.
- R9: Offsets outside 0x80 to 0xFF are not decoded. They read 0, raise no bad flag and change no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rev | input | 2 | Controller revision (1 or 2 enable grouping as per R5) |
| cfg_sec_ext | input | 1 | Security extensions present |
| cfg_num_irq | input | NUM_W | Number of implemented interrupts |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | OFS_W | Byte offset in the distributor space |
| req_wdata | input | 8 | Write data, bit i for interrupt 8k+i |
| req_secure | input | 1 | Access is secure |
| req_cpu | input | CPU_W | Index of the requesting CPU |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 8 | Read data (0 for writes and refused accesses) |
| rsp_bad | output | 1 | Bad register access pulse |
| grp_vec | output | N_CPU*N_IRQ | Group bit per CPU and interrupt |

## Verification
The hardest case is telling banked bits from shared ones, because both are written through the same byte port. The bench therefore writes different patterns to the same private byte from two CPUs. It then reads the byte back from those CPUs and from a third CPU that never wrote it, and inspects each CPU's slice of `grp_vec`. Refused accesses leave no trace in the response, so the bench first loads known values. It then sends the refused write under the blocking configuration, restores a permissive configuration, and checks by a secure read that the old value survived. The bad-register limit is exercised on both sides of `cfg_num_irq`. It is also exercised with `cfg_num_irq` set above `N_IRQ`, which checks the clamping.

// File: rtl/irq_group_pkg.sv
package irq_group_pkg;

    localparam int GRP_WIN_BASE = 'h80;
    localparam int PRIV_IRQS    = 32;
    localparam int PRIV_BYTES   = PRIV_IRQS / 8;

    typedef struct packed {
        logic       hit;
        logic       ok;
        logic       bad;
        logic       priv;
        logic [6:0] byte_idx;
    } grp_dec_t;

    typedef struct packed {
        logic       valid;
        logic [7:0] rdata;
        logic       bad;
    } grp_rsp_t;

endpackage

// File: rtl/irq_group_decode.sv
module irq_group_decode
    import irq_group_pkg::*;
#(
    parameter int N_IRQ = 96,
    parameter int OFS_W = 12,
    parameter int NUM_W = 7
) (
    input  logic [OFS_W-1:0] offset,
    input  logic [1:0]       rev,
    input  logic             sec_ext,
    input  logic             secure,
    input  logic [NUM_W-1:0] num_irq,
    output grp_dec_t         dec
);

    localparam logic [OFS_W-8:0] WIN_TAG = (OFS_W-7)'(GRP_WIN_BASE >> 7);

    logic groups_on;
    int   limit;
    int   first_id;

    always_comb begin
        groups_on    = (rev == 2'd2) || ((rev == 2'd1) && sec_ext);
        dec.hit      = (offset[OFS_W-1:7] == WIN_TAG);
        dec.byte_idx = offset[6:0];
        dec.ok       = groups_on && !(sec_ext && !secure);
        dec.priv     = (int'(offset[6:0]) < PRIV_BYTES);
        limit        = (int'(num_irq) > N_IRQ) ? N_IRQ : int'(num_irq);
        first_id     = int'(offset[6:0]) * 8;
        dec.bad      = dec.hit && dec.ok && (first_id >= limit);
    end

endmodule

// File: rtl/irq_group_store.sv
module irq_group_store
    import irq_group_pkg::*;
#(
    parameter int N_CPU = 4,
    parameter int N_IRQ = 96,
    parameter int CPU_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [6:0]             byte_idx,
    input  logic [CPU_W-1:0]       cpu,
    input  logic [7:0]             wdata,
    output logic [7:0]             rd_byte,
    output logic [N_CPU*N_IRQ-1:0] grp_vec
);

    localparam int N_BYTES   = N_IRQ / 8;
    localparam int SHR_BYTES = N_BYTES - PRIV_BYTES;

    logic [7:0] priv_d [N_CPU][PRIV_BYTES];
    logic [7:0] priv_q [N_CPU][PRIV_BYTES];
    logic [7:0] shr_d  [SHR_BYTES];
    logic [7:0] shr_q  [SHR_BYTES];

    always_comb begin
        priv_d  = priv_q;
        shr_d   = shr_q;
        rd_byte = 8'h00;
        for (int c = 0; c < N_CPU; c++) begin
            for (int b = 0; b < PRIV_BYTES; b++) begin
                if ((int'(cpu) == c) && (int'(byte_idx) == b)) begin
                    rd_byte = priv_q[c][b];
                    if (wr_en) priv_d[c][b] = wdata;
                end
            end
        end
        for (int j = 0; j < SHR_BYTES; j++) begin
            if (int'(byte_idx) == j + PRIV_BYTES) begin
                rd_byte = shr_q[j];
                if (wr_en) shr_d[j] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < N_CPU; c++)
                for (int b = 0; b < PRIV_BYTES; b++)
                    priv_q[c][b] <= 8'h00;
            for (int j = 0; j < SHR_BYTES; j++)
                shr_q[j] <= 8'h00;
        end else begin
            priv_q <= priv_d;
            shr_q  <= shr_d;
        end
    end

    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
        for (genvar i = 0; i < PRIV_IRQS; i++) begin : g_priv
            assign grp_vec[c*N_IRQ + i] = priv_q[c][i/8][i%8];
        end
        for (genvar i = PRIV_IRQS; i < N_IRQ; i++) begin : g_shr
            assign grp_vec[c*N_IRQ + i] = shr_q[(i-PRIV_IRQS)/8][(i-PRIV_IRQS)%8];
        end
    end

endmodule

// File: rtl/irq_group_bank.sv
module irq_group_bank
    import irq_group_pkg::*;
#(
    parameter int N_CPU = 4,
    parameter int N_IRQ = 96,
    parameter int OFS_W = 12,
    parameter int NUM_W = $clog2(N_IRQ + 1),
    parameter int CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             cfg_rev,
    input  logic                   cfg_sec_ext,
    input  logic [NUM_W-1:0]       cfg_num_irq,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [OFS_W-1:0]       req_offset,
    input  logic [7:0]             req_wdata,
    input  logic                   req_secure,
    input  logic [CPU_W-1:0]       req_cpu,
    output logic                   rsp_valid,
    output logic [7:0]             rsp_rdata,
    output logic                   rsp_bad,
    output logic [N_CPU*N_IRQ-1:0] grp_vec
);

    grp_dec_t   dec;
    grp_rsp_t   rsp_d, rsp_q;
    logic       take;
    logic       wr_en;
    logic [7:0] rd_byte;

    irq_group_decode #(
        .N_IRQ(N_IRQ), .OFS_W(OFS_W), .NUM_W(NUM_W)
    ) u_decode (
        .offset  (req_offset),
        .rev     (cfg_rev),
        .sec_ext (cfg_sec_ext),
        .secure  (req_secure),
        .num_irq (cfg_num_irq),
        .dec     (dec)
    );

    irq_group_store #(
        .N_CPU(N_CPU), .N_IRQ(N_IRQ), .CPU_W(CPU_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .byte_idx (dec.byte_idx),
        .cpu      (req_cpu),
        .wdata    (req_wdata),
        .rd_byte  (rd_byte),
        .grp_vec  (grp_vec)
    );

    always_comb begin
        take        = req_valid && dec.hit && dec.ok && !dec.bad;
        wr_en       = take && req_write;
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        rsp_d.bad   = req_valid && dec.bad;
        if (take && !req_write) rsp_d.rdata = rd_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_rdata = rsp_q.rdata;
    assign rsp_bad   = rsp_q.bad;

endmodule

// File: rtl/irq_group_bank_chk.sv
module irq_group_bank_chk #(
    parameter int N_CPU = 4,
    parameter int N_IRQ = 96,
    parameter int OFS_W = 12,
    parameter int NUM_W = 7,
    parameter int CPU_W = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [1:0]             cfg_rev,
    input logic                   cfg_sec_ext,
    input logic                   req_valid,
    input logic                   req_write,
    input logic [OFS_W-1:0]       req_offset,
    input logic                   req_secure,
    input logic                   rsp_valid,
    input logic [7:0]             rsp_rdata,
    input logic                   rsp_bad,
    input logic [N_CPU*N_IRQ-1:0] grp_vec
);

    logic no_groups;
    logic in_win;
    assign no_groups = !((cfg_rev == 2'd2) || ((cfg_rev == 2'd1) && cfg_sec_ext));
    assign in_win    = (int'(req_offset) >= 'h80) && (int'(req_offset) <= 'hFF);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (grp_vec == '0) && !rsp_valid);

    assert_rsp_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_rsp_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && !rsp_bad);

    assert_nogroup_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && no_groups) |=> (rsp_rdata == 8'h00) && !rsp_bad && $stable(grp_vec));

    assert_nonsec_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cfg_sec_ext && !req_secure) |=> (rsp_rdata == 8'h00) && !rsp_bad && $stable(grp_vec));

    assert_bad_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_bad |-> rsp_valid && (rsp_rdata == 8'h00) && $stable(grp_vec));

    assert_outside_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !in_win) |=> (rsp_rdata == 8'h00) && !rsp_bad && $stable(grp_vec));

    assert_read_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> $stable(grp_vec));

endmodule

bind irq_group_bank irq_group_bank_chk #(
    .N_CPU(N_CPU), .N_IRQ(N_IRQ), .OFS_W(OFS_W), .NUM_W(NUM_W), .CPU_W(CPU_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_rev     (cfg_rev),
    .cfg_sec_ext (cfg_sec_ext),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_offset  (req_offset),
    .req_secure  (req_secure),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .rsp_bad     (rsp_bad),
    .grp_vec     (grp_vec)
);

// File: tb/irq_group_bank_bench.sv
module irq_group_bank_bench;

    localparam int N_CPU = 4;
    localparam int N_IRQ = 96;
    localparam int OFS_W = 12;
    localparam int NUM_W = 7;
    localparam int CPU_W = 2;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [1:0]             cfg_rev = 2'd2;
    logic                   cfg_sec_ext = 1'b0;
    logic [NUM_W-1:0]       cfg_num_irq = NUM_W'(96);
    logic                   req_valid = 1'b0;
    logic                   req_write = 1'b0;
    logic [OFS_W-1:0]       req_offset = '0;
    logic [7:0]             req_wdata = '0;
    logic                   req_secure = 1'b0;
    logic [CPU_W-1:0]       req_cpu = '0;
    logic                   rsp_valid;
    logic [7:0]             rsp_rdata;
    logic                   rsp_bad;
    logic [N_CPU*N_IRQ-1:0] grp_vec;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    irq_group_bank #(
        .N_CPU(N_CPU), .N_IRQ(N_IRQ), .OFS_W(OFS_W), .NUM_W(NUM_W), .CPU_W(CPU_W)
    ) u_irq_group_bank (
        .clk(clk), .rst_n(rst_n), .cfg_rev(cfg_rev), .cfg_sec_ext(cfg_sec_ext),
        .cfg_num_irq(cfg_num_irq), .req_valid(req_valid), .req_write(req_write),
        .req_offset(req_offset), .req_wdata(req_wdata), .req_secure(req_secure),
        .req_cpu(req_cpu), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_bad(rsp_bad), .grp_vec(grp_vec)
    );

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    logic [7:0] r_data;
    logic       r_bad;
    logic       r_vld;

    task automatic access(input logic wr, input int ofs, input logic [7:0] wd,
                          input logic sec, input int cpu);
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = wr;
        req_offset = OFS_W'(ofs);
        req_wdata  = wd;
        req_secure = sec;
        req_cpu    = CPU_W'(cpu);
        @(negedge clk);
        req_valid  = 1'b0;
        r_vld  = rsp_valid;
        r_data = rsp_rdata;
        r_bad  = rsp_bad;
    endtask

    function automatic logic [7:0] vec_byte(input int cpu, input int first_id);
        logic [7:0] v;
        for (int i = 0; i < 8; i++) v[i] = grp_vec[cpu*N_IRQ + first_id + i];
        return v;
    endfunction

    task automatic t_reset;
        check_eq("R1 rsp_valid after reset", 32'(rsp_valid), 0);
        check_eq("R1 grp_vec after reset", 32'(grp_vec != '0), 0);
        access(1'b0, 'h80, 8'h00, 1'b1, 0);
        check_eq("R1 read 0x80 after reset", 32'(r_data), 0);
    endtask

    task automatic t_shared;
        access(1'b1, 'h85, 8'hA5, 1'b0, 1);
        check_eq("R8 write response valid", 32'(r_vld), 1);
        check_eq("R8 write rdata zero", 32'(r_data), 0);
        access(1'b0, 'h85, 8'h00, 1'b0, 0);
        check_eq("R3 shared read cpu0", 32'(r_data), 'hA5);
        access(1'b0, 'h85, 8'h00, 1'b0, 3);
        check_eq("R3 shared read cpu3", 32'(r_data), 'hA5);
        for (int c = 0; c < N_CPU; c++)
            check_eq("R2 grp_vec ids 40..47", 32'(vec_byte(c, 40)), 'hA5);
        check_eq("R2 neighbour byte untouched", 32'(vec_byte(0, 48)), 0);
    endtask

    task automatic t_banked;
        access(1'b1, 'h80, 8'h3C, 1'b0, 0);
        access(1'b1, 'h80, 8'hC1, 1'b0, 2);
        access(1'b0, 'h80, 8'h00, 1'b0, 0);
        check_eq("R4 banked read cpu0", 32'(r_data), 'h3C);
        access(1'b0, 'h80, 8'h00, 1'b0, 2);
        check_eq("R4 banked read cpu2", 32'(r_data), 'hC1);
        access(1'b0, 'h80, 8'h00, 1'b0, 1);
        check_eq("R4 banked read cpu1 untouched", 32'(r_data), 0);
        check_eq("R4 grp_vec cpu0 ids 0..7", 32'(vec_byte(0, 0)), 'h3C);
        check_eq("R4 grp_vec cpu2 ids 0..7", 32'(vec_byte(2, 0)), 'hC1);
        check_eq("R4 grp_vec cpu3 ids 0..7", 32'(vec_byte(3, 0)), 0);
    endtask

    task automatic t_nonsec;
        cfg_rev = 2'd2; cfg_sec_ext = 1'b1;
        access(1'b0, 'h85, 8'h00, 1'b0, 0);
        check_eq("R6 non-secure read zero", 32'(r_data), 0);
        check_eq("R6 non-secure read no bad", 32'(r_bad), 0);
        access(1'b1, 'h85, 8'h00, 1'b0, 0);
        access(1'b1, 'h80, 8'hFF, 1'b0, 0);
        access(1'b0, 'h8C, 8'h00, 1'b0, 0);
        check_eq("R6 non-secure out of range no bad", 32'(r_bad), 0);
        access(1'b0, 'h85, 8'h00, 1'b1, 0);
        check_eq("R6 shared kept after non-secure write", 32'(r_data), 'hA5);
        access(1'b0, 'h80, 8'h00, 1'b1, 0);
        check_eq("R6 private kept after non-secure write", 32'(r_data), 'h3C);
    endtask

    task automatic t_revision;
        cfg_rev = 2'd1; cfg_sec_ext = 1'b1;
        access(1'b0, 'h85, 8'h00, 1'b1, 0);
        check_eq("R5 rev1 with security reads", 32'(r_data), 'hA5);
        cfg_rev = 2'd1; cfg_sec_ext = 1'b0;
        access(1'b0, 'h85, 8'h00, 1'b1, 0);
        check_eq("R5 rev1 no security reads zero", 32'(r_data), 0);
        access(1'b1, 'h85, 8'hFF, 1'b1, 0);
        access(1'b0, 'h8C, 8'h00, 1'b1, 0);
        check_eq("R5 rev1 no security no bad", 32'(r_bad), 0);
        cfg_rev = 2'd0; cfg_sec_ext = 1'b1;
        access(1'b0, 'h85, 8'h00, 1'b1, 0);
        check_eq("R5 rev0 reads zero", 32'(r_data), 0);
        cfg_rev = 2'd2; cfg_sec_ext = 1'b0;
        access(1'b0, 'h85, 8'h00, 1'b0, 1);
        check_eq("R5 value kept after blocked write", 32'(r_data), 'hA5);
    endtask

    task automatic t_bad;
        cfg_num_irq = NUM_W'(64);
        access(1'b0, 'h87, 8'h00, 1'b0, 0);
        check_eq("R7 last in-range byte not bad", 32'(r_bad), 0);
        access(1'b0, 'h88, 8'h00, 1'b0, 0);
        check_eq("R7 first id 64 flagged bad", 32'(r_bad), 1);
        check_eq("R7 bad read data zero", 32'(r_data), 0);
        access(1'b1, 'h88, 8'h77, 1'b0, 0);
        check_eq("R7 bad write flagged", 32'(r_bad), 1);
        check_eq("R7 bad write changed nothing", 32'(vec_byte(0, 64)), 0);
        cfg_num_irq = NUM_W'(127);
        access(1'b0, 'h8C, 8'h00, 1'b0, 0);
        check_eq("R7 limit clamped to N_IRQ", 32'(r_bad), 1);
        access(1'b0, 'h8B, 8'h00, 1'b0, 0);
        check_eq("R7 id 88 in range when clamped", 32'(r_bad), 0);
        cfg_num_irq = NUM_W'(96);
    endtask

    task automatic t_timing;
        access(1'b1, 'h8B, 8'h5A, 1'b0, 2);
        access(1'b0, 'h8B, 8'h00, 1'b0, 1);
        check_eq("R8 response valid one cycle after read", 32'(r_vld), 1);
        check_eq("R8 write visible to next request", 32'(r_data), 'h5A);
        @(negedge clk);
        check_eq("R8 response lasts one cycle", 32'(rsp_valid), 0);
        check_eq("R8 bad idle low", 32'(rsp_bad), 0);
    endtask

    task automatic t_outside;
        logic [N_CPU*N_IRQ-1:0] snap;
        snap = grp_vec;
        access(1'b1, 'h40, 8'hFF, 1'b1, 0);
        access(1'b1, 'h100, 8'hFF, 1'b1, 0);
        check_eq("R9 outside write no bad", 32'(r_bad), 0);
        check_eq("R9 outside writes change nothing", 32'(grp_vec != snap), 0);
        access(1'b0, 'h7C, 8'h00, 1'b1, 0);
        check_eq("R9 outside read zero", 32'(r_data), 0);
        check_eq("R9 outside read valid", 32'(r_vld), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_shared;
        t_banked;
        t_nonsec;
        t_revision;
        t_bad;
        t_timing;
        t_outside;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule